// File: doc/BRIEF.md
# Configuration Page Access Guard

This block sits in front of a 64 KB configuration flash window. The window is split into sixteen 4 KB pages, and each page has a fixed protection policy. Every read, write, page-erase or chip-erase request is presented for one cycle. One cycle later the guard returns one of three verdicts: allow, deny or bus error. Pages 0x0 to 0x7 form the first panel and pages 0x8 to 0xF form the second. The page number is taken from the window offset, so a page's position fixes its policy.

Each panel has the following pages:

- one user-configuration page with a software write/erase lock;
- one write-once OTP page that can never be erased;
- one boot-configuration page with separate read and write/erase protection.

The first panel also has three open pages, a reserved hole and a factory calibration page that can only be read. The other second-panel pages are holes. The lock and protection bits can only be set, and only reset clears them. The guard keeps one sticky "already programmed" flag for each 16-byte OTP write word. This flag stands in for the non-volatile state of the array, so only reset clears it.

A chip-erase request is always allowed. Alongside the verdict, the guard returns a 16-bit mask of the pages the erase may touch.

Top module: `cfgGuard`

## Requirements
- R1: A request presented with `reqValid` high at a clock edge produces `respValid` high for exactly the following cycle. `respValid` is low in every other cycle. Operation codes on `reqOp` are 0 read, 1 write, 2 page erase and 3 chip erase. Verdict codes on `respCode` are 0 allow, 1 deny and 2 bus error.
- R2: An address outside 0x0A00_0000 to 0x0A00_FFFF gets a bus error for read, write and page erase. The page index is address bits [15:12].
- R3: Pages 0x6 and 0xB to 0xF are holes. Every read, write or page erase to a hole gets a bus error.
- R4: Calibration page 0x7 allows reads and denies writes and page erases.
- R5: OTP pages 0x1 and 0x9 allow reads and always deny page erase.
- R6: An OTP write word is address bits [11:4] within an OTP page, with a separate set of words per panel. The first write to a word is allowed and marks it. Every later write to that word is denied until reset. A write to an unmarked word in the same page is still allowed.
- R7: A pulse on `setBootRdProt[p]` makes reads of the boot page of panel p deny from then until reset. Panel 0 uses page 0x2 and panel 1 uses page 0xA. The pulse leaves that page's writes unaffected.
- R8: A pulse on `setBootWrProt[p]` makes writes and page erases of the boot page of panel p deny until reset. Reads of that page stay allowed.
- R9: A pulse on `setUserLock[p]` makes writes and page erases of the user page of panel p deny until reset. Panel 0 uses page 0x0 and panel 1 uses page 0x8. Reads stay allowed and the other panel is unaffected.
- R10: Open pages 0x3, 0x4 and 0x5 allow read, write and page erase.
- R11: A chip erase ignores the address and returns allow with `eraseMask` = 0xFD7D. The mask has every page bit set except calibration page 0x7 and OTP pages 0x1 and 0x9. `eraseMask` is zero with every other response and while idle.
- R12: A set pulse in the same cycle as a request does not affect that request. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears locks, protections and OTP marks |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqOp | input | 2 | Operation: 0 read, 1 write, 2 page erase, 3 chip erase |
| reqAddr | input | 32 | Byte address of the request |
| setBootRdProt | input | 2 | Per-panel set pulse for boot page read protection |
| setBootWrProt | input | 2 | Per-panel set pulse for boot page write/erase protection |
| setUserLock | input | 2 | Per-panel set pulse for user page write/erase lock |
| respValid | output | 1 | Verdict valid, one cycle after the request |
| respCode | output | 2 | Verdict: 0 allow, 1 deny, 2 bus error |
| eraseMask | output | 16 | Pages a chip erase may clear; zero otherwise |

## Verification
The hardest states to reach from the ports are the OTP word flags, because a word's verdict depends on the whole history of writes to it. The vector table therefore walks a chosen order:

- a first write to a word;
- a repeat of that write;
- a write to a different byte of the same word;
- a write to the neighbouring word;
- a write to the same offset in the other panel.

After the table, a mid-run reset is applied and the first word is written again. This shows that the flags are cleared only by reset. The ordering between a set pulse and a request is reached by driving both in one cycle. A lone request then follows to show the new state.

// File: rtl/cfgGuardPkg.sv
package cfgGuardPkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_CHIP  = 2'd3
  } opE;

  typedef enum logic [1:0] {
    RESP_ALLOW  = 2'd0,
    RESP_DENY   = 2'd1,
    RESP_BUSERR = 2'd2,
    RESP_RSVD   = 2'd3
  } respE;

  typedef enum logic [2:0] {
    PG_USER,
    PG_OTP,
    PG_BOOT,
    PG_OPEN,
    PG_CAL,
    PG_HOLE
  } pageKindE;

  // Strobes from control to datapath for one request
  typedef struct packed {
    logic respFire;
    respE code;
    logic chipErase;
    logic otpMark;
  } strobeT;

  // Fixed page policy map; position in the window selects the kind
  function automatic pageKindE pageKindOf(input logic [3:0] pg);
    case (pg)
      4'h0, 4'h8:       pageKindOf = PG_USER;
      4'h1, 4'h9:       pageKindOf = PG_OTP;
      4'h2, 4'hA:       pageKindOf = PG_BOOT;
      4'h3, 4'h4, 4'h5: pageKindOf = PG_OPEN;
      4'h7:             pageKindOf = PG_CAL;
      default:          pageKindOf = PG_HOLE;
    endcase
  endfunction

endpackage

// File: rtl/cfgGuardCtrl.sv
module cfgGuardCtrl
  import cfgGuardPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE = 32'h0A00_0000,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 16,
  parameter int NUM_PAGES  = 16
) (
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           bootRdProt,
  input  logic [1:0]           bootWrProt,
  input  logic [1:0]           userLock,
  input  logic                 otpUsed,
  output logic [$clog2(PAGE_BYTES/WORD_BYTES):0] otpIdx,
  output strobeT               strb
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int WORD_W = $clog2(WORD_BYTES);
  localparam int PG_W   = $clog2(NUM_PAGES);
  localparam int WIN_W  = PAGE_W + PG_W;

  logic            inWin;
  logic [PG_W-1:0] page;
  logic            panel;
  pageKindE        kind;
  opE              op;
  logic            isMod;
  logic            unusedLow;

  assign inWin     = reqAddr[ADDR_W-1:WIN_W] == WIN_BASE[ADDR_W-1:WIN_W];
  assign page      = reqAddr[WIN_W-1:PAGE_W];
  assign panel     = page[PG_W-1];
  assign kind      = pageKindOf(4'(page));
  assign op        = opE'(reqOp);
  assign isMod     = (op == OP_WRITE) || (op == OP_ERASE);
  assign otpIdx    = {panel, reqAddr[PAGE_W-1:WORD_W]};
  assign unusedLow = ^reqAddr[WORD_W-1:0];

  always_comb begin
    strb.respFire  = 1'b0;
    strb.code      = RESP_ALLOW;
    strb.chipErase = 1'b0;
    strb.otpMark   = 1'b0;
    if (reqValid) begin
      strb.respFire = 1'b1;
      if (op == OP_CHIP) begin
        strb.chipErase = 1'b1;
      end else if (!inWin || kind == PG_HOLE) begin
        strb.code = RESP_BUSERR;
      end else begin
        case (kind)
          PG_USER: if (isMod && userLock[panel]) strb.code = RESP_DENY;
          PG_BOOT: begin
            if (op == OP_READ && bootRdProt[panel]) strb.code = RESP_DENY;
            if (isMod && bootWrProt[panel])         strb.code = RESP_DENY;
          end
          PG_CAL:  if (isMod) strb.code = RESP_DENY;
          PG_OTP: begin
            if (op == OP_ERASE) strb.code = RESP_DENY;
            else if (op == OP_WRITE) begin
              if (otpUsed) strb.code = RESP_DENY;
              else         strb.otpMark = 1'b1;
            end
          end
          default: strb.code = RESP_ALLOW;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgGuardData.sv
module cfgGuardData
  import cfgGuardPkg::*;
#(
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 16,
  parameter int NUM_PAGES  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strb,
  input  logic [$clog2(PAGE_BYTES/WORD_BYTES):0] otpIdx,
  input  logic [1:0]           setBootRdProt,
  input  logic [1:0]           setBootWrProt,
  input  logic [1:0]           setUserLock,
  output logic                 otpUsed,
  output logic [1:0]           bootRdProt,
  output logic [1:0]           bootWrProt,
  output logic [1:0]           userLock,
  output logic                 respValid,
  output logic [1:0]           respCode,
  output logic [NUM_PAGES-1:0] eraseMask
);
  localparam int OTP_N = 2 * (PAGE_BYTES / WORD_BYTES);

  logic [OTP_N-1:0]     otpWritten;
  logic [NUM_PAGES-1:0] chipMask;

  // Pages a chip erase may clear: all but calibration and OTP
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_mask
    localparam pageKindE K = pageKindOf(4'(g));
    assign chipMask[g] = !(K == PG_OTP || K == PG_CAL);
  end

  assign otpUsed = otpWritten[otpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootRdProt <= '0;
      bootWrProt <= '0;
      userLock   <= '0;
      otpWritten <= '0;
    end else begin
      bootRdProt <= bootRdProt | setBootRdProt;
      bootWrProt <= bootWrProt | setBootWrProt;
      userLock   <= userLock   | setUserLock;
      if (strb.otpMark) otpWritten[otpIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCode  <= 2'd0;
      eraseMask <= '0;
    end else begin
      respValid <= strb.respFire;
      respCode  <= strb.respFire ? strb.code : RESP_ALLOW;
      eraseMask <= strb.chipErase ? chipMask : '0;
    end
  end
endmodule

// File: rtl/cfgGuard.sv
module cfgGuard
  import cfgGuardPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE = 32'h0A00_0000,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 16,
  parameter int NUM_PAGES  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           setBootRdProt,
  input  logic [1:0]           setBootWrProt,
  input  logic [1:0]           setUserLock,
  output logic                 respValid,
  output logic [1:0]           respCode,
  output logic [NUM_PAGES-1:0] eraseMask
);
  localparam int IDX_W = $clog2(PAGE_BYTES / WORD_BYTES) + 1;

  strobeT           strb;
  logic [IDX_W-1:0] otpIdx;
  logic             otpUsed;
  logic [1:0]       bootRdProt, bootWrProt, userLock;

  cfgGuardCtrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .PAGE_BYTES(PAGE_BYTES),
    .WORD_BYTES(WORD_BYTES), .NUM_PAGES(NUM_PAGES)
  ) uCtrl (
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .bootRdProt(bootRdProt), .bootWrProt(bootWrProt), .userLock(userLock),
    .otpUsed(otpUsed), .otpIdx(otpIdx), .strb(strb)
  );

  cfgGuardData #(
    .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES), .NUM_PAGES(NUM_PAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .otpIdx(otpIdx),
    .setBootRdProt(setBootRdProt), .setBootWrProt(setBootWrProt),
    .setUserLock(setUserLock), .otpUsed(otpUsed),
    .bootRdProt(bootRdProt), .bootWrProt(bootWrProt), .userLock(userLock),
    .respValid(respValid), .respCode(respCode), .eraseMask(eraseMask)
  );
endmodule

// File: rtl/cfgGuardChk.sv
module cfgGuardChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqOp,
  input logic [31:0] reqAddr,
  input logic        respValid,
  input logic [1:0]  respCode,
  input logic [15:0] eraseMask
);
  logic       inWin;
  logic [3:0] pg;
  logic       isWrite;
  assign inWin   = reqAddr[31:16] == 16'h0A00;
  assign pg      = reqAddr[15:12];
  assign isWrite = reqValid && reqOp == 2'd1;

  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  // R1
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  // R3
  hole_buserr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'd3 && inWin &&
     (pg == 4'h6 || pg >= 4'hB)) |=> respCode == 2'd2);
  // R4
  cal_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inWin && pg == 4'h7 && (reqOp == 2'd1 || reqOp == 2'd2))
    |=> respCode == 2'd1);
  // R5
  otp_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd2 && inWin && (pg == 4'h1 || pg == 4'h9))
    |=> respCode == 2'd1);
  // R6
  otp_rewrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && $past(isWrite) && reqAddr == $past(reqAddr) && inWin &&
     (pg == 4'h1 || pg == 4'h9)) |=> respCode == 2'd1);
  // R11
  chip_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eraseMask[1] == 1'b0 && eraseMask[7] == 1'b0 && eraseMask[9] == 1'b0));
  // R11
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqOp == 2'd3) |=> eraseMask == 16'h0);
endmodule

bind cfgGuard cfgGuardChk uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .reqAddr(reqAddr), .respValid(respValid), .respCode(respCode),
  .eraseMask(eraseMask)
);

// File: tb/sim_cfgGuard.sv
module sim_cfgGuard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = 32'h0;
  logic [1:0]  setBootRdProt = 2'b0, setBootWrProt = 2'b0, setUserLock = 2'b0;
  logic        respValid;
  logic [1:0]  respCode;
  logic [15:0] eraseMask;

  int compared = 0;
  int mismatched = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, ER = 2'd2, CE = 2'd3;
  localparam logic [1:0] OK = 2'd0, DN = 2'd1, BE = 2'd2;

  // {op, address, expected verdict} from reset state
  localparam logic [35:0] VEC [0:20] = '{
    {RD, 32'h0A00_0000, OK},  // R9 baseline
    {WR, 32'h0A00_0010, OK},  // R9
    {ER, 32'h0A00_0000, OK},  // R9
    {RD, 32'h0A00_1000, OK},  // R5
    {ER, 32'h0A00_1000, DN},  // R5
    {WR, 32'h0A00_1020, OK},  // R6 first write
    {WR, 32'h0A00_1020, DN},  // R6 repeat
    {WR, 32'h0A00_102C, DN},  // R6 same word
    {WR, 32'h0A00_1030, OK},  // R6 next word
    {WR, 32'h0A00_9020, OK},  // R6 other panel
    {RD, 32'h0A00_2000, OK},  // R7 baseline
    {WR, 32'h0A00_3000, OK},  // R10
    {ER, 32'h0A00_5000, OK},  // R10
    {RD, 32'h0A00_6000, BE},  // R3
    {WR, 32'h0A00_B000, BE},  // R3
    {ER, 32'h0A00_F000, BE},  // R3
    {RD, 32'h0A00_7000, OK},  // R4
    {WR, 32'h0A00_7100, DN},  // R4
    {ER, 32'h0A00_7000, DN},  // R4
    {RD, 32'h0A01_0000, BE},  // R2
    {RD, 32'h09FF_FFFC, BE}   // R2
  };

  cfgGuard u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .setBootRdProt(setBootRdProt),
    .setBootWrProt(setBootWrProt), .setUserLock(setUserLock),
    .respValid(respValid), .respCode(respCode), .eraseMask(eraseMask)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, verdict is checked one cycle later at negedge
  task automatic doReq(input logic [1:0] op, input logic [31:0] a,
                       input logic [1:0] exp, input string req);
    reqValid = 1'b1; reqOp = op; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " valid"}, 32'(respValid), 32'd1);
    check({req, " code"}, 32'(respCode), 32'(exp));
    @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] rd, input logic [1:0] wr,
                       input logic [1:0] lk);
    setBootRdProt = rd; setBootWrProt = wr; setUserLock = lk;
    @(negedge clk);
    setBootRdProt = 2'b0; setBootWrProt = 2'b0; setUserLock = 2'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(respValid), 32'd0);
    check("R11 reset mask", 32'(eraseMask), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 21; i++)
      doReq(VEC[i][35:34], VEC[i][33:2], VEC[i][1:0], $sformatf("vec%0d", i));

    // R1 idle: no response without a request
    @(negedge clk);
    check("R1 idle", 32'(respValid), 32'd0);

    // R11 chip erase mask, address ignored
    reqValid = 1'b1; reqOp = CE; reqAddr = 32'h1234_5678;
    @(negedge clk);
    reqValid = 1'b0;
    check("R11 code", 32'(respCode), 32'(OK));
    check("R11 mask", 32'(eraseMask), 32'h0000_FD7D);
    @(negedge clk);
    check("R11 mask clears", 32'(eraseMask), 32'd0);

    // R7 read protection on panel 0 boot page
    pulse(2'b01, 2'b00, 2'b00);
    doReq(RD, 32'h0A00_2000, DN, "R7 read protected");
    doReq(WR, 32'h0A00_2010, OK, "R7 write unaffected");
    doReq(RD, 32'h0A00_A000, OK, "R7 other panel");

    // R8 write/erase protection on panel 1 boot page
    pulse(2'b00, 2'b10, 2'b00);
    doReq(WR, 32'h0A00_A000, DN, "R8 write");
    doReq(ER, 32'h0A00_A000, DN, "R8 erase");
    doReq(RD, 32'h0A00_A040, OK, "R8 read");

    // R9 user lock on panel 0
    pulse(2'b00, 2'b00, 2'b01);
    doReq(WR, 32'h0A00_0000, DN, "R9 write locked");
    doReq(ER, 32'h0A00_0000, DN, "R9 erase locked");
    doReq(RD, 32'h0A00_0000, OK, "R9 read");
    doReq(WR, 32'h0A00_8000, OK, "R9 other panel");

    // R12 set pulse with a request in the same cycle
    setUserLock = 2'b10;
    doReq(WR, 32'h0A00_8000, OK, "R12 same cycle");
    setUserLock = 2'b00;
    doReq(WR, 32'h0A00_8000, DN, "R12 next request");

    // Reset clears OTP marks and locks (R6, R9)
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doReq(WR, 32'h0A00_1020, OK, "R6 after reset");
    doReq(WR, 32'h0A00_0000, OK, "R9 after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule